// File: doc/BRIEF.md
# Residue-Feedback Delta-Sigma Conversion Sequencer

This block is the digital side of one row of a first-order, single-bit delta-sigma converter. It does not use a single long counting window. Instead, it splits a conversion into several short windows. During each window it counts how many modulator cycles produced a comparator decision of 1. When a window closes, the count is latched and the counter is cleared. A feedback-select strobe then tells the analog side to resample the integrator residue as the input for the next window. With the defaults, two windows of 16 modulator cycles give an 8-bit word in 32 modulator cycles instead of 256. Other settings work the same way: two windows of 32 give 10 bits, and three windows of 8 give 9 bits.

Every modulator cycle spans three master-clock cycles, and exactly one phase enable is high in each of them. Phase one is precharge, phase two is integrate and input-sample, and phase three is reference selection. An auxiliary reference-initialise enable is derived from phase one.

The controller has six states. IDLE waits for `start`. SAMPLE raises the sample/hold pulse for one clock. RUN steps through the phases until the last modulator cycle of the window ends. LATCH captures the count. FEED pulses feedback-select and then returns to RUN. DONE presents the assembled word.

The transitions are:
- IDLE→SAMPLE on `start`.
- SAMPLE→RUN always.
- RUN→LATCH after phase three of the last modulator cycle.
- LATCH→FEED when further windows remain.
- LATCH→DONE after the final window.
- FEED→RUN always.
- DONE→IDLE always.

Top module: `rfds_sequencer`

## Requirements
- R1: A synchronous reset, applied at any point including mid-conversion, leaves `ph_pre`, `ph_int`, `ph_ref`, `ref_init`, `sh_pulse`, `latch_out`, `fb_sel`, `out_en` and `done` low and `result` zero, with the block idle.
- R2: A `start` sampled high while idle produces exactly one `sh_pulse` in the following clock; `ph_pre` is high in the clock after that.
- R3: Each modulator cycle occupies three consecutive clocks with `ph_pre`, then `ph_int`, then `ph_ref` high; no two phase enables are ever high together.
- R4: `ref_init` is high only together with `ph_pre`, and only in the first modulator cycle of each window, so it occurs once per window.
- R5: A window lasts WIN_LEN modulator cycles, and its count is the number of those cycles in which `comp_bit` is 1 at the clock where `ph_ref` is high.
- R6: A window count saturates at 2^log2(WIN_LEN)-1 (15 by default), so a window of all ones does not wrap.
- R7: At the end of each window, `latch_out` is high for one clock and the count restarts from zero; after every window except the last, `fb_sel` is high for the one clock that follows `latch_out`.
- R8: `result` is the concatenation of the window counts, with the first window in the most significant log2(WIN_LEN) bits.
- R9: `done` is high for exactly one clock, NUM_WIN*(3*WIN_LEN+2) clocks after the edge that samples `start`. `out_en` rises with `done` and stays high until the next `sh_pulse` clock.
- R10: `start` is ignored while a conversion is in progress; no further `sh_pulse` or `done` results from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Conversion request |
| comp_bit | input | 1 | Single-bit comparator decision from the modulator |
| ph_pre | output | 1 | Phase one enable (precharge) |
| ph_int | output | 1 | Phase two enable (integrate, input sample) |
| ph_ref | output | 1 | Phase three enable (reference select) |
| ref_init | output | 1 | Reference initialise enable, first phase one of each window |
| sh_pulse | output | 1 | Sample/hold control pulse opening a conversion |
| latch_out | output | 1 | Window count latch strobe |
| fb_sel | output | 1 | Residue feedback select strobe |
| out_en | output | 1 | Result valid indication |
| done | output | 1 | One-clock conversion complete pulse |
| result | output | NUM_WIN*log2(WIN_LEN) | Assembled conversion word |

## Verification
The checks assume that `comp_bit` is stable in the clock where `ph_ref` is high. They also assume that `start` is synchronous to `clk` and that WIN_LEN is a power of two no smaller than 2. The bench behaves like a modulator: it changes `comp_bit` only on a falling edge seen during `ph_pre`, choosing each bit from a per-window ones count. This keeps the decision stable through phases two and three. `start` and `rst` are driven on falling edges only. One `start` is raised deliberately in the middle of a conversion to exercise the ignore rule.

// File: rtl/rfds_pkg.sv
package rfds_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_SAMPLE,
        S_RUN,
        S_LATCH,
        S_FEED,
        S_DONE
    } seq_state_t;
endpackage

// File: rtl/rfds_phase_gen.sv
module rfds_phase_gen (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    output logic [2:0] ph
);
    logic [2:0] ring;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            ring <= 3'b001;
        end else begin
            ring <= {ring[1:0], ring[2]};
        end
    end

    assign ph = run ? ring : 3'b000;

    a_r3_pre_then_int: assert property (@(posedge clk) disable iff (rst)
        ph[0] |=> ph[1]);
    a_r3_int_then_ref: assert property (@(posedge clk) disable iff (rst)
        ph[1] |=> ph[2]);
endmodule

// File: rtl/rfds_ones_counter.sv
module rfds_ones_counter #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] MAXV = {CW{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc && cnt != MAXV) begin
            cnt <= cnt + 1'b1;
        end
    end

    a_r6_hold_at_max: assert property (@(posedge clk) disable iff (rst)
        (cnt == MAXV && inc && !clr) |=> cnt == MAXV);
    a_r7_restart_zero: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt == '0);
endmodule

// File: rtl/rfds_result_asm.sv
module rfds_result_asm #(
    parameter int CW = 4,
    parameter int NW = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             load,
    input  logic [CW-1:0]    part,
    output logic [CW*NW-1:0] word
);
    localparam int RW = CW * NW;

    generate
        if (NW == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    word <= '0;
                end else if (load) begin
                    word <= part;
                end
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    word <= '0;
                end else if (load) begin
                    word <= {word[RW-CW-1:0], part};
                end
            end
        end
    endgenerate

    a_r8_low_gets_part: assert property (@(posedge clk) disable iff (rst)
        (load && !clr) |=> word[CW-1:0] == $past(part));
endmodule

// File: rtl/rfds_sequencer.sv
module rfds_sequencer #(
    parameter int WIN_LEN = 16,
    parameter int NUM_WIN = 2
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               start,
    input  logic                               comp_bit,
    output logic                               ph_pre,
    output logic                               ph_int,
    output logic                               ph_ref,
    output logic                               ref_init,
    output logic                               sh_pulse,
    output logic                               latch_out,
    output logic                               fb_sel,
    output logic                               out_en,
    output logic                               done,
    output logic [NUM_WIN*$clog2(WIN_LEN)-1:0] result
);
    import rfds_pkg::*;

    localparam int CW    = $clog2(WIN_LEN);
    localparam int RW    = CW * NUM_WIN;
    localparam int WIN_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
    localparam logic [CW-1:0]    LAST_CYC = CW'(WIN_LEN - 1);
    localparam logic [WIN_W-1:0] LAST_WIN = WIN_W'(NUM_WIN - 1);

    seq_state_t       state, nxt;
    logic [CW-1:0]    cyc_idx;
    logic [WIN_W-1:0] win_idx;
    logic             oe_q;
    logic [2:0]       ph;
    logic [CW-1:0]    win_cnt;
    logic             run, last_cyc, last_win;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    assign last_cyc = (cyc_idx == LAST_CYC);
    assign last_win = (win_idx == LAST_WIN);

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (start) nxt = S_SAMPLE;
            S_SAMPLE: nxt = S_RUN;
            S_RUN:    if (ph[2] && last_cyc) nxt = S_LATCH;
            S_LATCH:  nxt = last_win ? S_DONE : S_FEED;
            S_FEED:   nxt = S_RUN;
            S_DONE:   nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // sequencing counters
    always_ff @(posedge clk) begin
        if (rst || state != S_RUN) begin
            cyc_idx <= '0;
        end else if (ph[2]) begin
            cyc_idx <= cyc_idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || state == S_SAMPLE) begin
            win_idx <= '0;
        end else if (state == S_FEED) begin
            win_idx <= win_idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_q <= 1'b0;
        end else if (state == S_DONE) begin
            oe_q <= 1'b1;
        end else if (state == S_IDLE && start) begin
            oe_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        run       = 1'b0;
        sh_pulse  = 1'b0;
        latch_out = 1'b0;
        fb_sel    = 1'b0;
        done      = 1'b0;
        unique case (state)
            S_IDLE:   ;
            S_SAMPLE: sh_pulse  = 1'b1;
            S_RUN:    run       = 1'b1;
            S_LATCH:  latch_out = 1'b1;
            S_FEED:   fb_sel    = 1'b1;
            S_DONE:   done      = 1'b1;
            default:  ;
        endcase
    end

    assign ph_pre   = ph[0];
    assign ph_int   = ph[1];
    assign ph_ref   = ph[2];
    assign ref_init = ph[0] && (cyc_idx == '0);
    assign out_en   = done || oe_q;

    rfds_phase_gen u_phase (
        .clk (clk),
        .rst (rst),
        .run (run),
        .ph  (ph)
    );

    rfds_ones_counter #(.CW(CW)) u_count (
        .clk (clk),
        .rst (rst),
        .clr (latch_out || sh_pulse),
        .inc (ph[2] && comp_bit),
        .cnt (win_cnt)
    );

    rfds_result_asm #(.CW(CW), .NW(NUM_WIN)) u_asm (
        .clk  (clk),
        .rst  (rst),
        .clr  (sh_pulse),
        .load (latch_out),
        .part (win_cnt),
        .word (result)
    );

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE) |-> !(ph_pre || ph_int || ph_ref || latch_out || fb_sel));
    a_r2_sample_then_pre: assert property (@(posedge clk) disable iff (rst)
        sh_pulse |=> ph_pre);
    a_r3_no_overlap: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ph_pre, ph_int, ph_ref}));
    a_r7_feed_after_latch: assert property (@(posedge clk) disable iff (rst)
        fb_sel |-> $past(latch_out));
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r9_done_valid: assert property (@(posedge clk) disable iff (rst)
        done |-> out_en);
    a_r10_busy_ignores: assert property (@(posedge clk) disable iff (rst)
        (state == S_RUN && start) |=> !sh_pulse);
endmodule

// File: tb/sim_rfds_sequencer.sv
module sim_rfds_sequencer;
    localparam int W  = 16;
    localparam int NW = 2;
    localparam int CW = 4;
    localparam int RW = CW * NW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic comp_bit = 1'b0;
    logic ph_pre, ph_int, ph_ref, ref_init, sh_pulse, latch_out, fb_sel, out_en, done;
    logic [RW-1:0] result;

    int total = 0;
    int bad = 0;
    int pat0 = 0, pat1 = 0, k = 0;
    int n_sh = 0, n_fb = 0, n_lat = 0, n_ri = 0, n_ref = 0, n_done = 0, n_ovl = 0, n_ord = 0, n_ri_bad = 0;
    int fb_bad = 0;
    logic prev_pre = 0, prev_int = 0, prev_lat = 0;

    always #5 clk = ~clk;

    rfds_sequencer #(.WIN_LEN(W), .NUM_WIN(NW)) u0 (
        .clk(clk), .rst(rst), .start(start), .comp_bit(comp_bit),
        .ph_pre(ph_pre), .ph_int(ph_int), .ph_ref(ph_ref), .ref_init(ref_init),
        .sh_pulse(sh_pulse), .latch_out(latch_out), .fb_sel(fb_sel),
        .out_en(out_en), .done(done), .result(result)
    );

    // modulator model and pulse monitor
    always @(negedge clk) begin
        if (sh_pulse) begin n_sh++; k = 0; end
        if (fb_sel) n_fb++;
        if (fb_sel && !prev_lat) fb_bad++;
        if (latch_out) n_lat++;
        if (ref_init) n_ri++;
        if (ref_init && !ph_pre) n_ri_bad++;
        if (ph_ref) n_ref++;
        if (done) n_done++;
        if ((int'(ph_pre) + int'(ph_int) + int'(ph_ref)) > 1) n_ovl++;
        if (ph_int && !prev_pre) n_ord++;
        if (ph_ref && !prev_int) n_ord++;
        if (ph_pre) begin
            comp_bit = ((k % W) < ((k / W) == 0 ? pat0 : pat1));
            k++;
        end
        prev_pre = ph_pre;
        prev_int = ph_int;
        prev_lat = latch_out;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic zero_counts();
        @(posedge clk);
        n_sh = 0; n_fb = 0; n_lat = 0; n_ri = 0; n_ref = 0; n_done = 0;
        n_ovl = 0; n_ord = 0; n_ri_bad = 0; fb_bad = 0;
    endtask

    function automatic int sat(input int n);
        return (n > (1 << CW) - 1) ? (1 << CW) - 1 : n;
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(!(ph_pre || ph_int || ph_ref || ref_init || sh_pulse || latch_out || fb_sel),
            "R1 strobes low in reset", 1, 0);
        chk(!out_en && !done, "R1 out_en/done low", int'(out_en) + int'(done), 0);
        chk(result == '0, "R1 result zero", int'(result), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!(ph_pre || sh_pulse), "R1 idle after reset", int'(ph_pre) + int'(sh_pulse), 0);
    endtask

    task automatic t_convert(input int n0, input int n1, input bit poke);
        int lat;
        int expv;
        pat0 = n0; pat1 = n1;
        expv = (sat(n0) << CW) | sat(n1);
        zero_counts();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(sh_pulse, "R2 sample pulse after start", int'(sh_pulse), 1);
        chk(!out_en, "R9 out_en low in sample clock", int'(out_en), 0);
        @(negedge clk);
        chk(ph_pre, "R2 phase one follows sample", int'(ph_pre), 1);
        lat = 1;
        while (!done && lat < 1000) begin
            if (poke && lat == 40) start = 1'b1;
            if (poke && lat == 41) start = 1'b0;
            @(negedge clk);
            lat++;
        end
        chk(lat == NW * (3 * W + 2), "R9 done latency", lat, NW * (3 * W + 2));
        chk(result == RW'(expv), "R8 result word", int'(result), expv);
        chk(out_en, "R9 out_en with done", int'(out_en), 1);
        chk(n_sh == 1, "R2 one sample pulse", n_sh, 1);
        chk(n_lat == NW, "R7 latch pulses", n_lat, NW);
        chk(n_fb == NW - 1 && fb_bad == 0, "R7 feedback pulses", n_fb, NW - 1);
        chk(n_ri == NW && n_ri_bad == 0, "R4 ref_init once per window", n_ri, NW);
        chk(n_ref == NW * W, "R5 modulator cycles counted", n_ref, NW * W);
        chk(n_ovl == 0 && n_ord == 0, "R3 phase order and overlap", n_ovl + n_ord, 0);
        @(negedge clk);
        chk(!done, "R9 done one clock", int'(done), 0);
        repeat (5) @(negedge clk);
        chk(out_en, "R9 out_en held until next sample", int'(out_en), 1);
        chk(n_sh == 1 && n_done == 1, "R10 no extra conversion", n_sh + n_done, 2);
        chk(result == RW'(expv), "R8 result held", int'(result), expv);
    endtask

    task automatic t_midrun_reset();
        pat0 = 9; pat1 = 9;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (30) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!(ph_pre || ph_int || ph_ref || latch_out || fb_sel || done || out_en),
            "R1 mid-run reset quiets outputs", 1, 0);
        chk(result == '0, "R1 mid-run reset clears result", int'(result), 0);
        rst = 1'b0;
        zero_counts();
        repeat (20) @(negedge clk);
        chk(n_sh == 0 && n_ref == 0, "R1 stays idle after reset", n_sh + n_ref, 0);
    endtask

    initial begin
        t_reset();
        t_convert(11, 3, 1'b0);   // R5 R8 typical
        t_convert(0, 0, 1'b0);    // R5 all zeros
        t_convert(16, 16, 1'b0);  // R6 saturation both windows
        t_convert(16, 0, 1'b0);   // R6 R8 window order
        t_convert(8, 5, 1'b1);    // R10 start mid-conversion
        t_midrun_reset();
        t_convert(5, 12, 1'b0);   // R1 recovery
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule